// File: doc/BRIEF.md
# Supply Low-Voltage Monitor Controller

This block is the digital half of a supply-voltage monitor. Three comparator outputs from the analog side enter it asynchronously: "supply below the falling threshold", "supply above the rising threshold" and "supply below the reset threshold". Each is synchronised and edge-detected. From those edges the block keeps a hysteretic level status, records separate sticky flags for a drop and for a recovery, and raises one interrupt request from the flags that software has enabled. It also drives an active-low internal reset. That reset stays active while the reset comparator is asserted. It is released only after a fixed number of clean clock cycles.

Software brings the monitor up in a fixed order. It first sets the master enable, which starts a stabilisation down-counter. Once that count expires it sets the interrupt enables. Shutdown runs in the opposite order. The enables must be cleared before the master enable, and a write that would drop the master enable while an enable is still set is refused and recorded as an error. The input `rst_n` is expected to come from an upstream synchroniser: it asserts asynchronously and deasserts on a clock edge.

Top module: `lvd_ctrl`

## Requirements
- R1: After `rst_n` the control readback `ctrl_o` is 0, the status readback `stat_o` is 0, `level_o` is 1, `irq_o` is 0 and `sys_rst_n_o` is 0.
- R2: A control write (`wr_sel_i`=0) with bit 0 = 1 while the master enable is clear sets the master enable (`ctrl_o[0]`). The same write loads a counter of STAB_CYCLES. `stat_o[2]` reads 1 while that counter is non-zero and 0 once it has run out.
- R3: The drop enable (`ctrl_o[1]`, data bit 1) and the rise enable (`ctrl_o[2]`, data bit 2) take the written value only when the master enable is already set and `stat_o[2]` is 0. Otherwise they keep their value.
- R4: A control write with bit 0 = 0 while either interrupt enable is set changes no control bit and sets the sticky error bit `stat_o[3]`. When both enables are clear, the same write clears the master enable.
- R5: While detection is active, a rising edge of the synchronised falling-threshold input with `level_o`=1 drives `level_o` to 0 and sets the drop flag `stat_o[0]`. Detection is active when the master enable is set and `stat_o[2]`=0.
- R6: While detection is active, a rising edge of the synchronised rising-threshold input with `level_o`=0 drives `level_o` to 1 and sets the rise flag `stat_o[1]`.
- R7: Only edges act. A comparator input held high does not set its flag again after the flag has been cleared, and a falling-threshold edge while `level_o` is 0 has no effect.
- R8: A status write (`wr_sel_i`=1) clears the drop flag, the rise flag or the error bit wherever data bit 0, 1 or 3 respectively is 0. A 1 in the data leaves the bit unchanged. A new flag event in the same cycle wins over the clear.
- R9: `irq_o` is 1 exactly when (drop flag AND drop enable) OR (rise flag AND rise enable).
- R10: While the synchronised reset-threshold input is 1, `sys_rst_n_o` is 0, `level_o` is forced to 1 and no flag is set.
- R11: `sys_rst_n_o` rises once RST_CYCLES consecutive clock cycles have passed with `rst_n` high and the reset-threshold input low.
- R12: While detection is inactive, comparator edges change neither `level_o` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cmp_fall_i | input | 1 | Comparator: supply below the falling threshold (asynchronous) |
| cmp_rise_i | input | 1 | Comparator: supply above the rising threshold (asynchronous) |
| cmp_por_i | input | 1 | Comparator: supply below the reset threshold (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 4 | Write data |
| ctrl_o | output | 3 | Control readback {rise enable, drop enable, master enable} |
| stat_o | output | 4 | Status readback {error, stabilising, rise flag, drop flag} |
| level_o | output | 1 | Hysteretic level status, 1 when the supply is good |
| irq_o | output | 1 | Interrupt request |
| sys_rst_n_o | output | 1 | Internal reset, active low |

## Verification
A wrong stabilisation count shows up on `stat_o[2]` and in whether an enable write sticks, within one cycle of the expected expiry. A wrong level or edge state shows up on `level_o` and on the flag bits three cycles after a comparator change, and that is the synchroniser depth plus one register. Sweeps over every control-write value, and over every enable combination with both flags set, expose a faulty disable guard or interrupt term on the very next cycle. A faulty release counter moves the rise of `sys_rst_n_o` away from the exact cycle R11 predicts.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  // control register bit positions (software decodes these)
  localparam int CB_MASTER = 0;
  localparam int CB_DROP   = 1;
  localparam int CB_RISE   = 2;
  // status register bit positions
  localparam int SB_DROP   = 0;
  localparam int SB_RISE   = 1;
  localparam int SB_BUSY   = 2;
  localparam int SB_ERR    = 3;

  localparam int N_CMP     = 3;
  localparam int CI_FALL   = 0;
  localparam int CI_RISE   = 1;
  localparam int CI_POR    = 2;

  typedef struct packed {
    logic rise_en;
    logic drop_en;
    logic master;
  } ctrl_t;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= async_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
    assign edge_o[g] = s2_q[g] & ~s3_q[g];
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
  import lvd_pkg::*;
#(
  parameter int STAB_CYCLES = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_edge_i,
  input  logic       rise_edge_i,
  input  logic       por_lvl_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [2:0] ctrl_o,
  output logic [3:0] stat_o,
  output logic       level_o,
  output logic       irq_o
);
  localparam int SW = $clog2(STAB_CYCLES + 1);

  ctrl_t         ctrl_q, ctrl_d;
  logic [SW-1:0] stab_q, stab_d;
  logic          df_q, df_d, rf_q, rf_d, err_q, err_d, lvl_q, lvl_d;
  logic          busy, detect, wr_ctrl, wr_stat;

  assign busy    = (stab_q != '0);
  assign detect  = ctrl_q.master & ~busy;
  assign wr_ctrl = wr_en_i & ~wr_sel_i;
  assign wr_stat = wr_en_i &  wr_sel_i;

  always_comb begin
    ctrl_d = ctrl_q;
    stab_d = busy ? stab_q - SW'(1) : stab_q;
    df_d   = df_q;
    rf_d   = rf_q;
    err_d  = err_q;
    lvl_d  = lvl_q;

    if (wr_ctrl) begin
      if (wr_data_i[CB_MASTER]) begin
        if (!ctrl_q.master) begin
          ctrl_d.master = 1'b1;
          stab_d        = SW'(STAB_CYCLES);
        end else if (!busy) begin
          ctrl_d.drop_en = wr_data_i[CB_DROP];
          ctrl_d.rise_en = wr_data_i[CB_RISE];
        end
      end else if (ctrl_q.drop_en | ctrl_q.rise_en) begin
        err_d = 1'b1;
      end else begin
        ctrl_d.master = 1'b0;
        stab_d        = '0;
      end
    end

    if (wr_stat) begin
      if (!wr_data_i[SB_DROP]) df_d  = 1'b0;
      if (!wr_data_i[SB_RISE]) rf_d  = 1'b0;
      if (!wr_data_i[SB_ERR])  err_d = 1'b0;
    end

    if (por_lvl_i) begin
      lvl_d = 1'b1;
    end else if (detect) begin
      if (fall_edge_i && lvl_q) begin
        lvl_d = 1'b0;
        df_d  = 1'b1;
      end else if (rise_edge_i && !lvl_q) begin
        lvl_d = 1'b1;
        rf_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stab_q <= '0;
      df_q   <= 1'b0;
      rf_q   <= 1'b0;
      err_q  <= 1'b0;
      lvl_q  <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      stab_q <= stab_d;
      df_q   <= df_d;
      rf_q   <= rf_d;
      err_q  <= err_d;
      lvl_q  <= lvl_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign stat_o  = {err_q, busy, rf_q, df_q};
  assign level_o = lvl_q;
  assign irq_o   = (df_q & ctrl_q.drop_en) | (rf_q & ctrl_q.rise_en);

  // R4: an error only appears on a refused write, so the master stays set
  p_err_keeps_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(ctrl_q.master) && ctrl_q.master));

  // R3: an enable can only turn on once stabilisation is complete
  p_drop_en_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.drop_en) |-> ($past(ctrl_q.master) && $past(stab_q == '0)));

  p_rise_en_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.rise_en) |-> ($past(ctrl_q.master) && $past(stab_q == '0)));

  // R8: the drop flag only goes away through a zero write
  p_drop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(df_q) && !$past(wr_stat && !wr_data_i[SB_DROP])) |-> df_q);

  // R5: a fall of the level always comes with the drop flag
  p_level_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> df_q);

  // R10: the reset comparator forces the level high
  p_por_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    por_lvl_i |=> lvl_q);
endmodule

// File: rtl/lvd_rel_cnt.sv
module lvd_rel_cnt #(
  parameter int RST_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_lvl_i,
  output logic rel_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done = (cnt_q == CW'(RST_CYCLES));

  always_comb begin
    cnt_d = cnt_q;
    if (por_lvl_i)  cnt_d = '0;
    else if (!done) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rel_o = done & ~por_lvl_i;

  // R10: the reset comparator keeps the internal reset active
  p_por_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    por_lvl_i |=> !rel_o);

  // R11: the counter never runs past its limit
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RST_CYCLES));

  // R11: once released without a new reset condition, the release holds
  p_rel_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rel_o) && !por_lvl_i) |-> rel_o);
endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
  import lvd_pkg::*;
#(
  parameter int STAB_CYCLES = 10000,
  parameter int RST_CYCLES  = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_fall_i,
  input  logic       cmp_rise_i,
  input  logic       cmp_por_i,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [3:0] wr_data_i,
  output logic [2:0] ctrl_o,
  output logic [3:0] stat_o,
  output logic       level_o,
  output logic       irq_o,
  output logic       sys_rst_n_o
);
  logic [N_CMP-1:0] cmp_raw, cmp_lvl, cmp_edge;

  always_comb begin
    cmp_raw          = '0;
    cmp_raw[CI_FALL] = cmp_fall_i;
    cmp_raw[CI_RISE] = cmp_rise_i;
    cmp_raw[CI_POR]  = cmp_por_i;
  end

  lvd_sync #(.W(N_CMP)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(cmp_raw),
    .lvl_o  (cmp_lvl),
    .edge_o (cmp_edge)
  );

  lvd_regs #(.STAB_CYCLES(STAB_CYCLES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_edge_i(cmp_edge[CI_FALL]),
    .rise_edge_i(cmp_edge[CI_RISE]),
    .por_lvl_i  (cmp_lvl[CI_POR]),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl_o),
    .stat_o     (stat_o),
    .level_o    (level_o),
    .irq_o      (irq_o)
  );

  lvd_rel_cnt #(.RST_CYCLES(RST_CYCLES)) u_rel (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_lvl_i(cmp_lvl[CI_POR]),
    .rel_o    (sys_rst_n_o)
  );

  // R9: a request needs at least one flag raised
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_o[SB_DROP] | stat_o[SB_RISE]));
endmodule

// File: tb/lvd_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvd_ctrl_tb_top;
  localparam int STAB = 16;
  localparam int RSTC = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_fall = 1'b0, cmp_rise = 1'b0, cmp_por = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] wr_data = '0;
  logic [2:0] ctrl;
  logic [3:0] stat;
  logic       level, irq, sys_rst_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lvd_ctrl #(.STAB_CYCLES(STAB), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmp_fall_i(cmp_fall), .cmp_rise_i(cmp_rise), .cmp_por_i(cmp_por),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .stat_o(stat), .level_o(level), .irq_o(irq),
    .sys_rst_n_o(sys_rst_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic bring_up();
    wr(1'b0, 4'b0001);
    cyc(STAB + 2);
    wr(1'b0, 4'b0111);
  endtask

  task automatic pulse_fall();
    cmp_fall = 1'b1; cyc(4); cmp_fall = 1'b0; cyc(4);
  endtask

  task automatic pulse_rise();
    cmp_rise = 1'b1; cyc(4); cmp_rise = 1'b0; cyc(4);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(2);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ctrl", int'(ctrl), 0);
    chk("R1 stat", int'(stat), 0);
    chk("R1 level", int'(level), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sys_rst_n", int'(sys_rst_n), 0);

    // R11 release timing
    cyc(RSTC - 1);
    chk("R11 before release", int'(sys_rst_n), 0);
    cyc(1);
    chk("R11 at release", int'(sys_rst_n), 1);

    // R12 detection inactive with master clear
    pulse_fall();
    chk("R12 level master off", int'(level), 1);
    chk("R12 flags master off", int'(stat[1:0]), 0);

    // R2 / R3 bring-up
    wr(1'b0, 4'b0111);
    chk("R3 enables ignored with master clear", int'(ctrl), 1);
    chk("R2 busy after master set", int'(stat[2]), 1);
    wr(1'b0, 4'b0111);
    chk("R3 enables ignored while busy", int'(ctrl), 1);
    pulse_fall();
    chk("R12 flags while busy", int'(stat[1:0]), 0);
    cyc(STAB);
    chk("R2 busy cleared", int'(stat[2]), 0);
    wr(1'b0, 4'b0111);
    chk("R3 enables accepted", int'(ctrl), 7);

    // R5 / R9 drop
    cmp_fall = 1'b1;
    cyc(4);
    chk("R5 level dropped", int'(level), 0);
    chk("R5 drop flag", int'(stat[0]), 1);
    chk("R9 irq on drop", int'(irq), 1);
    cyc(6);
    wr(1'b1, 4'b1110);
    chk("R8 drop cleared", int'(stat[0]), 0);
    cyc(6);
    chk("R7 held input no re-set", int'(stat[0]), 0);
    chk("R9 irq gone", int'(irq), 0);
    cmp_fall = 1'b0;
    cyc(4);
    pulse_fall();
    chk("R7 fall while low no effect", int'(stat[0]), 0);
    chk("R7 level stays low", int'(level), 0);

    // R6 rise
    cmp_rise = 1'b1;
    cyc(4);
    chk("R6 level recovered", int'(level), 1);
    chk("R6 rise flag", int'(stat[1]), 1);
    chk("R9 irq on rise", int'(irq), 1);
    cmp_rise = 1'b0;
    wr(1'b1, 4'b1111);
    chk("R8 write one keeps flag", int'(stat[1]), 1);
    wr(1'b1, 4'b1101);
    chk("R8 rise cleared", int'(stat[1]), 0);
    cyc(4);
    pulse_rise();
    chk("R7 rise while high no effect", int'(stat[1]), 0);

    // R9 sweep over enables with both flags set
    pulse_fall();
    pulse_rise();
    chk("R9 both flags", int'(stat[1:0]), 3);
    for (int en = 0; en < 4; en++) begin
      wr(1'b0, 4'(((en & 3) << 1) | 1));
      chk($sformatf("R9 irq en=%0d", en), int'(irq), (en != 0) ? 1 : 0);
    end
    wr(1'b0, 4'b0111);

    // R4 sweep over every control write from the fully enabled state
    for (int v = 0; v < 8; v++) begin
      do_reset();
      bring_up();
      wr(1'b0, 4'(v));
      chk($sformatf("R4 ctrl v=%0d", v), int'(ctrl), (v & 1) ? v : 7);
      chk($sformatf("R4 err v=%0d", v), int'(stat[3]), (v & 1) ? 0 : 1);
    end
    // R4 error clear and legal ordered disable
    wr(1'b1, 4'b0111);
    chk("R8 error cleared", int'(stat[3]), 0);
    wr(1'b0, 4'b0001);
    wr(1'b0, 4'b0000);
    chk("R4 ordered disable", int'(ctrl), 0);
    chk("R4 no error on ordered disable", int'(stat[3]), 0);

    // R10 reset-threshold comparator
    bring_up();
    cyc(RSTC);
    pulse_fall();
    chk("R10 setup level low", int'(level), 0);
    cmp_por = 1'b1;
    cyc(4);
    chk("R10 level forced high", int'(level), 1);
    chk("R10 sys reset active", int'(sys_rst_n), 0);
    pulse_rise();
    chk("R10 no rise flag", int'(stat[1]), 0);
    cyc(100);
    chk("R10 still in reset", int'(sys_rst_n), 0);
    cmp_por = 1'b0;
    cyc(RSTC);
    chk("R11 not yet released after por", int'(sys_rst_n), 0);
    cyc(3);
    chk("R11 released after por", int'(sys_rst_n), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule